// File: doc/BRIEF.md
# Dual-format serial audio receiver

This block takes stereo audio from a three-wire serial link (a bit clock, a word-select clock and one data line) and turns it into parallel 24-bit left and right samples. A single select input chooses between left-justified framing and I2S framing. Everything runs on the rising edge of the bit clock, which is also the block's only clock.

Each word-select level marks one channel slot. The receiver gathers up to 24 bits per slot, MSB first, in two's complement. It ignores any bits after the 24th and fills missing low bits with zeros when a slot is short. When a right slot closes after a left slot, the pair is presented together with a one-cycle strobe. The format select is taken only at the word-select transition that opens a frame. The receiver also counts high pulses on the select line within each frame and raises a flag when that count reaches an illegal level.

Top module: `serial_audio_rx`

## Requirements
- R1: Data is sampled on each rising `bclk` edge. Samples are 24 bits, MSB first, two's complement, and appear unchanged on `left_o` / `right_o`.
- R2: With `fmt_sel` = 0 (left-justified), `lrclk` = 1 marks the left slot and `lrclk` = 0 the right slot. The MSB is the bit sampled on the same rising edge that first sees the new `lrclk` level.
- R3: With `fmt_sel` = 1 (I2S), `lrclk` = 0 marks the left slot and `lrclk` = 1 the right slot. The bit sampled on the edge that first sees the new `lrclk` level is discarded, and the MSB is the bit on the following edge.
- R4: Bits after the 24th in a slot have no effect on the sample.
- R5: If a slot ends before 24 bits are taken, the bits not received are zero. In left-justified mode an N-cycle slot yields N bits; in I2S mode it yields N-1 bits.
- R6: `valid_o` is high for exactly one cycle, the cycle after the rising edge that sees the `lrclk` transition ending a right slot that followed a left slot. `left_o` and `right_o` change only together with that strobe and hold their values otherwise.
- R7: `fmt_sel` is taken only at the `lrclk` transition that opens a left slot under its current value. Toggling it inside a frame and restoring it before the next transition does not change the samples. Switching format costs one extra `lrclk` transition, because the left level differs between the formats.
- R8: `fmt_err_o` goes high in the cycle after the 8th rising edge of `fmt_sel` seen within one frame. It stays high until the next frame-opening transition. With 7 or fewer rising edges in a frame it stays low.
- R9: After reset `valid_o`, `fmt_err_o`, `left_o` and `right_o` are 0. The first `lrclk` transition after reset only starts framing, so no strobe occurs until a full left and right pair has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all logic uses its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to `bclk` |
| lrclk | input | 1 | Word-select (frame) clock |
| sdata | input | 1 | Serial data line |
| fmt_sel | input | 1 | Format select: 0 left-justified, 1 I2S |
| left_o | output | 24 | Last complete left sample |
| right_o | output | 24 | Last complete right sample |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| fmt_err_o | output | 1 | Too many select-line pulses in the current frame |

## Verification
The bench aims at the one-bit offset between the two formats. A receiver that got it wrong would shift every I2S sample one place, bringing in the extra bit and dropping the LSB. It drives random data after bit 24 and in the I2S lead-in slot, so a design that kept shifting would corrupt the low bits. It uses short slots in both modes to show whether zero-filling works or stale bits from the previous slot leak through. It toggles the select line inside frames 3, 7 and 8 times, which separates a counter that is off by one, one that never clears at the frame boundary, and a receiver that lets a mid-frame change alter its framing.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic {
      FMT_LEFTJ = 1'b0,
      FMT_I2S   = 1'b1
   } srx_fmt_e;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } srx_ch_e;

   // Word-select level that marks the left slot in a given format
   function automatic logic lr_is_left(input srx_fmt_e fmt, input logic lr);
      return (fmt == FMT_I2S) ? ~lr : lr;
   endfunction

endpackage

// File: rtl/srx_edge_track.sv
module srx_edge_track
   import srx_pkg::*;
(
   input  logic     bclk,
   input  logic     rst_n,
   input  logic     lrclk,
   input  logic     fmt_sel,
   output logic     lr_edge,
   output logic     frame_start,
   output srx_fmt_e slot_fmt,
   output srx_ch_e  slot_ch
);

   logic     lr_q;
   logic     seen_q;
   srx_fmt_e mode_q;
   srx_fmt_e sel_now;

   assign sel_now = srx_fmt_e'(fmt_sel);

   always_ff @(posedge bclk) begin
      if (!rst_n) begin
         lr_q   <= 1'b0;
         seen_q <= 1'b0;
         mode_q <= FMT_LEFTJ;
      end else begin
         lr_q   <= lrclk;
         seen_q <= 1'b1;
         if (frame_start) begin
            mode_q <= sel_now;
         end
      end
   end

   always_comb begin
      lr_edge     = seen_q && (lrclk != lr_q);
      frame_start = lr_edge && lr_is_left(sel_now, lrclk);
      slot_fmt    = frame_start ? sel_now : mode_q;
      slot_ch     = frame_start ? CH_LEFT : CH_RIGHT;
   end

endmodule

// File: rtl/srx_slot_deser.sv
module srx_slot_deser
   import srx_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                bclk,
   input  logic                rst_n,
   input  logic                slot_start,
   input  srx_fmt_e            slot_fmt,
   input  logic                sdata,
   output logic [SAMPLE_W-1:0] word
);

   localparam int CNT_W = $clog2(SAMPLE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);

   logic [CNT_W-1:0]    cnt_q;
   logic                active_q;
   logic                lead_bit;
   logic                shift_ok;
   logic [SAMPLE_W-1:0] word_nxt;

   assign lead_bit = slot_start && (slot_fmt == FMT_LEFTJ);
   assign shift_ok = !slot_start && active_q && (cnt_q < CNT_FULL);

   always_ff @(posedge bclk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (slot_start) begin
         cnt_q    <= lead_bit ? CNT_W'(1) : '0;
         active_q <= 1'b1;
      end else if (shift_ok) begin
         cnt_q    <= cnt_q + CNT_W'(1);
      end
   end

   // Each bit position is written only while the counter points at it
   for (genvar i = 0; i < SAMPLE_W; i++) begin : g_bit
      localparam logic [CNT_W-1:0] POS = CNT_W'(SAMPLE_W - 1 - i);
      logic hit;
      assign hit = shift_ok && (cnt_q == POS);
      if (i == SAMPLE_W - 1) begin : g_msb
         assign word_nxt[i] = slot_start ? (lead_bit & sdata)
                            : (hit ? sdata : word[i]);
      end else begin : g_rest
         assign word_nxt[i] = slot_start ? 1'b0
                            : (hit ? sdata : word[i]);
      end
   end

   always_ff @(posedge bclk) begin
      if (!rst_n) begin
         word <= '0;
      end else begin
         word <= word_nxt;
      end
   end

endmodule

// File: rtl/srx_sel_monitor.sv
module srx_sel_monitor #(
   parameter int PULSE_LIMIT = 8
) (
   input  logic bclk,
   input  logic rst_n,
   input  logic fmt_sel,
   input  logic frame_start,
   output logic err
);

   localparam int CW = $clog2(PULSE_LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(PULSE_LIMIT);

   logic          sel_q;
   logic          seen_q;
   logic          rise;
   logic [CW-1:0] pulse_cnt_q;

   assign rise = seen_q && fmt_sel && !sel_q;

   always_ff @(posedge bclk) begin
      if (!rst_n) begin
         sel_q       <= 1'b0;
         seen_q      <= 1'b0;
         pulse_cnt_q <= '0;
      end else begin
         sel_q  <= fmt_sel;
         seen_q <= 1'b1;
         if (frame_start) begin
            pulse_cnt_q <= rise ? CW'(1) : '0;
         end else if (rise && (pulse_cnt_q != LIM)) begin
            pulse_cnt_q <= pulse_cnt_q + CW'(1);
         end
      end
   end

   assign err = (pulse_cnt_q >= LIM);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import srx_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int PULSE_LIMIT = 8
) (
   input  logic                bclk,
   input  logic                rst_n,
   input  logic                lrclk,
   input  logic                sdata,
   input  logic                fmt_sel,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o,
   output logic                fmt_err_o
);

   if (SAMPLE_W < 8 || SAMPLE_W > 32) begin : g_bad_width
      $error("serial_audio_rx: SAMPLE_W must lie in 8..32");
   end
   if (PULSE_LIMIT < 2) begin : g_bad_limit
      $error("serial_audio_rx: PULSE_LIMIT must be at least 2");
   end

   logic                lr_edge;
   logic                frame_start;
   srx_fmt_e            slot_fmt;
   srx_ch_e             slot_ch;
   logic [SAMPLE_W-1:0] word;
   logic [SAMPLE_W-1:0] left_hold_q;
   logic                have_left_q;
   logic                ch_active_q;
   srx_ch_e             cur_ch_q;

   srx_edge_track u_edge (
      .bclk        (bclk),
      .rst_n       (rst_n),
      .lrclk       (lrclk),
      .fmt_sel     (fmt_sel),
      .lr_edge     (lr_edge),
      .frame_start (frame_start),
      .slot_fmt    (slot_fmt),
      .slot_ch     (slot_ch)
   );

   srx_slot_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
      .bclk       (bclk),
      .rst_n      (rst_n),
      .slot_start (lr_edge),
      .slot_fmt   (slot_fmt),
      .sdata      (sdata),
      .word       (word)
   );

   srx_sel_monitor #(.PULSE_LIMIT(PULSE_LIMIT)) u_selmon (
      .bclk        (bclk),
      .rst_n       (rst_n),
      .fmt_sel     (fmt_sel),
      .frame_start (frame_start),
      .err         (fmt_err_o)
   );

   // Slot bookkeeping: a closing slot is filed by its channel
   always_ff @(posedge bclk) begin
      if (!rst_n) begin
         left_hold_q <= '0;
         have_left_q <= 1'b0;
         ch_active_q <= 1'b0;
         cur_ch_q    <= CH_LEFT;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (lr_edge) begin
            ch_active_q <= 1'b1;
            cur_ch_q    <= slot_ch;
            if (ch_active_q) begin
               if (cur_ch_q == CH_LEFT) begin
                  left_hold_q <= word;
                  have_left_q <= 1'b1;
               end else if (have_left_q) begin
                  left_o      <= left_hold_q;
                  right_o     <= word;
                  valid_o     <= 1'b1;
                  have_left_q <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int SAMPLE_W = 24
) (
   input logic                bclk,
   input logic                rst_n,
   input logic                lrclk,
   input logic                fmt_sel,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o,
   input logic                valid_o,
   input logic                fmt_err_o
);

   // R6: the strobe never lasts two cycles
   a_r6_valid_single: assert property (@(posedge bclk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R6: outputs move only with the strobe
   a_r6_hold_outputs: assert property (@(posedge bclk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   // R6: a strobe follows a word-select transition
   a_r6_valid_after_edge: assert property (@(posedge bclk) disable iff (!rst_n)
      valid_o |-> ($past(lrclk) != $past(lrclk, 2)));

   // R8: the flag rises only after a high level on the select line
   a_r8_err_after_rise: assert property (@(posedge bclk) disable iff (!rst_n)
      $rose(fmt_err_o) |-> $past(fmt_sel));

   // R8: the flag clears only at a word-select transition
   a_r8_err_clears_on_edge: assert property (@(posedge bclk) disable iff (!rst_n)
      $fell(fmt_err_o) |-> ($past(lrclk) != $past(lrclk, 2)));

endmodule

bind serial_audio_rx srx_checker #(.SAMPLE_W(SAMPLE_W)) u_srx_checker (
   .bclk      (bclk),
   .rst_n     (rst_n),
   .lrclk     (lrclk),
   .fmt_sel   (fmt_sel),
   .left_o    (left_o),
   .right_o   (right_o),
   .valid_o   (valid_o),
   .fmt_err_o (fmt_err_o)
);

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;

   logic        bclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lrclk = 1'b0;
   logic        sdata = 1'b0;
   logic        fmt_sel = 1'b0;
   logic [23:0] left_o;
   logic [23:0] right_o;
   logic        valid_o;
   logic        fmt_err_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [47:0] exp_q[$];
   logic [23:0] last_l = '0;
   logic [23:0] last_r = '0;
   bit          prev_valid = 0;

   always #5 bclk = ~bclk;

   serial_audio_rx i_serial_audio_rx (
      .bclk      (bclk),
      .rst_n     (rst_n),
      .lrclk     (lrclk),
      .sdata     (sdata),
      .fmt_sel   (fmt_sel),
      .left_o    (left_o),
      .right_o   (right_o),
      .valid_o   (valid_o),
      .fmt_err_o (fmt_err_o)
   );

   task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive_cycle(input logic lr, input logic d, input logic fs);
      @(negedge bclk);
      lrclk   = lr;
      sdata   = d;
      fmt_sel = fs;
   endtask

   // Driver: one full frame, expected pair pushed to the scoreboard
   task automatic send_frame(input logic fmt, input logic [23:0] l, input logic [23:0] r,
                             input int nbits, input int npulses);
      int keep;
      logic [23:0] mask;
      logic left_lvl;
      keep = fmt ? nbits - 1 : nbits;
      if (keep > 24) keep = 24;
      mask = 24'hFFFFFF << (24 - keep);
      exp_q.push_back({l & mask, r & mask});
      left_lvl = fmt ? 1'b0 : 1'b1;
      for (int ch = 0; ch < 2; ch++) begin
         logic [23:0] w;
         w = (ch == 0) ? l : r;
         for (int k = 0; k < nbits; k++) begin
            int idx;
            logic d;
            logic fs;
            idx = fmt ? k - 1 : k;
            d = (idx >= 0 && idx < 24) ? w[23 - idx] : 1'($urandom % 2);
            fs = fmt;
            if (ch == 0 && k >= 2 && k < 2 + 2 * npulses)
               fs = ((k - 2) % 2 == 0) ? ~fmt : fmt;
            if (ch == 1 && k == nbits - 1) begin
               @(negedge bclk);
               // R8 flag state at the end of the frame
               check(fmt_err_o == (npulses >= 8), "R8 pulse flag", {47'd0, fmt_err_o},
                     {47'd0, (npulses >= 8)});
               lrclk = ch[0] ? ~left_lvl : left_lvl;
               sdata = d;
               fmt_sel = fs;
            end else begin
               drive_cycle(ch[0] ? ~left_lvl : left_lvl, d, fs);
            end
         end
      end
   endtask

   // R7: a format change needs one extra word-select transition
   task automatic switch_fmt(input logic new_fmt);
      for (int k = 0; k < 4; k++) drive_cycle(~lrclk ^ (k != 0), 1'b0, new_fmt);
   endtask

   // Monitor: pops the scoreboard on every strobe
   always @(negedge bclk) begin
      if (rst_n && !done) begin
         if (valid_o) begin
            if (prev_valid) check(1'b0, "R6 strobe longer than one cycle", 48'd1, 48'd0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 strobe with no pair sent", {left_o, right_o}, 48'd0);
            end else begin
               logic [47:0] e;
               e = exp_q.pop_front();
               check({left_o, right_o} == e, "R1 R2 R3 R4 R5 sample pair", {left_o, right_o}, e);
            end
            last_l = left_o;
            last_r = right_o;
         end else if (left_o != last_l || right_o != last_r) begin
            check(1'b0, "R6 outputs moved without strobe", {left_o, right_o}, {last_l, last_r});
         end
         prev_valid = valid_o;
      end
   end

   initial begin
      repeat (200000) @(posedge bclk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge bclk);
      rst_n = 1'b1;
      @(negedge bclk);
      // R9 reset state
      check(valid_o == 1'b0, "R9 valid after reset", {47'd0, valid_o}, 48'd0);
      check(fmt_err_o == 1'b0, "R9 flag after reset", {47'd0, fmt_err_o}, 48'd0);
      check(left_o == '0, "R9 left after reset", {24'd0, left_o}, 48'd0);
      check(right_o == '0, "R9 right after reset", {24'd0, right_o}, 48'd0);
      repeat (3) drive_cycle(1'b0, 1'b0, 1'b0);

      // R2 left-justified, R4 extra bits, R7 mid-frame toggles
      send_frame(1'b0, 24'h123456, 24'hABCDEF, 32, 0);
      send_frame(1'b0, 24'h800000, 24'h7FFFFF, 48, 3);
      send_frame(1'b0, 24'hFFFFFF, 24'h000001, 24, 0);
      // R5 short slot, left-justified
      send_frame(1'b0, 24'hA5A5A5, 24'h5A5A5A, 12, 0);
      // R8 eight pulses in left-justified mode
      send_frame(1'b0, 24'h0F0F0F, 24'hF0F0F0, 32, 8);
      send_frame(1'b0, 24'h13579B, 24'h2468AC, 32, 0);

      switch_fmt(1'b1);
      // R3 I2S framing
      send_frame(1'b1, 24'hC0FFEE, 24'h0BADF0, 32, 0);
      send_frame(1'b1, 24'h800001, 24'hFFFFFE, 25, 0);
      // R5 short slot, I2S
      send_frame(1'b1, 24'hFFFFFF, 24'hFFFFFF, 10, 0);
      // R8 limit minus one, then the limit
      send_frame(1'b1, 24'h112233, 24'h445566, 48, 7);
      send_frame(1'b1, 24'h778899, 24'hAABBCC, 48, 8);
      send_frame(1'b1, 24'hDDEEFF, 24'h102030, 32, 0);

      switch_fmt(1'b0);
      send_frame(1'b0, 24'h654321, 24'hFEDCBA, 32, 0);
      // flush: opening transition of one more frame ends the last right slot
      repeat (4) drive_cycle(1'b1, 1'b0, 1'b0);
      repeat (2) @(negedge bclk);
      // R6 every pair sent was presented exactly once
      check(exp_q.size() == 0, "R6 pairs left undelivered", 48'(exp_q.size()), 48'd0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule